// File: doc/BRIEF.md
# Handshake Parallel Port Block

This block drives two byte-wide bidirectional ports (A and B) and one six-bit port (C) from a six-bit port-control field. Ports A and B are each set to input or output by one control bit. Port C can be a plain input, a plain output, or it can give up three of its pins, or all six, to carry strobe, buffer-full and interrupt lines for A and B. With those lines in place a port moves data by strobed transfers: a peripheral strobe latches input data, and a CPU write hands output data to the peripheral.

The bus decoder outside the block turns register accesses into one-cycle read and write strobes for each port. It also supplies the control field. The block returns read data and a six-bit status word. At the pins it provides input, output and output-enable vectors, which a pad ring combines into tri-state pins. Each of A and B has one handshake channel, built as a small state machine. Its states are HS_OFF (handshake not in use), IN_WAIT (input buffer empty), IN_STB (strobe held low, data captured), IN_FULL (strobe released, data waiting for the CPU), OUT_EMPTY (peripheral has taken the data) and OUT_FULL (CPU data waiting for the peripheral).

The channel transitions are as follows:
- Any state goes to HS_OFF when the handshake is disabled.
- HS_OFF goes to IN_WAIT or OUT_EMPTY on entry. A direction change while the handshake is active performs the same entry.
- IN_WAIT goes to IN_STB on a strobe falling edge.
- IN_STB goes to IN_FULL on a strobe rising edge.
- IN_FULL goes to IN_WAIT on a CPU read.
- OUT_EMPTY goes to OUT_FULL on a CPU write.
- OUT_FULL goes to OUT_EMPTY on a strobe falling edge with no write in the same cycle.

Top module: `hsk_pio`

## Requirements
- R1: While rst_n is low and after its release, the output latches of A, B and C read zero, both channels are in HS_OFF, and status bits 0, 1, 3 and 4 are zero.
- R2: cmd_port bit 0 sets port A, and bit 1 sets port B, to output (1) or input (0). In output mode all bits of that port's oe are 1; in input mode they are 0.
- R3: A port's output latch is held at zero while the port is in input mode, and writes to it have no effect. After a switch from input to output the port therefore drives zero until it is written.
- R4: A read returns the output latch when the port is an output. When it is an input, the read returns the live pins, or the strobe-captured byte when the handshake is active. Port C returns, bit by bit, the driven value when the bit is an output and the pin when it is an input.
- R5: cmd_port[3:2] selects the port C mode. 00: all six pins are inputs, the C latch is held at zero and C writes are ignored. 11: all six are outputs. 01: pc[0] carries A interrupt, pc[1] A buffer-full, pc[2] is the A strobe input, and pc[5:3] are outputs. 10: as 01, and in addition pc[3] carries B interrupt, pc[4] B buffer-full and pc[5] is the B strobe input.
- R6: On entry to the handshake, an input port starts with buffer-full 0 and interrupt 0. An output port starts with buffer-full 0 and interrupt 1.
- R7: Strobed input: a low strobe captures the pin byte and sets buffer-full. The strobe's return high sets interrupt if the port's enable (cmd_port bit 4 for A, bit 5 for B) is 1. A CPU read of the port then clears both.
- R8: Strobed output: a CPU write sets buffer-full and clears interrupt. A strobe falling edge then clears buffer-full and, if the port's enable is 1, sets interrupt.
- R9: status bit 0 is A interrupt, bit 1 A buffer-full, bit 2 A enable, bit 3 B interrupt, bit 4 B buffer-full, bit 5 B enable.
- R10: Writing an output port with the value it already drives leaves its pin vector unchanged in every cycle.
- R11: Each strobe pin passes through a SYNC_STAGES-flop synchronizer. With the default of two stages, a strobe change made between clock edges shows in buffer-full after the third rising edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_port | input | 6 | Port-control field of the command byte |
| wr_data | input | W | Write data from the bus |
| wr_a | input | 1 | One-cycle write strobe for port A |
| wr_b | input | 1 | One-cycle write strobe for port B |
| wr_c | input | 1 | One-cycle write strobe for port C |
| rd_a | input | 1 | One-cycle read strobe for port A |
| rd_b | input | 1 | One-cycle read strobe for port B |
| rd_c | input | 1 | One-cycle read strobe for port C |
| rd_a_data | output | W | Port A read data |
| rd_b_data | output | W | Port B read data |
| rd_c_data | output | 6 | Port C read data |
| status | output | 6 | Port status word |
| pa_in | input | W | Port A pin levels |
| pa_out | output | W | Port A drive value |
| pa_oe | output | W | Port A output enables |
| pb_in | input | W | Port B pin levels |
| pb_out | output | W | Port B drive value |
| pb_oe | output | W | Port B output enables |
| pc_in | input | 6 | Port C pin levels |
| pc_out | output | 6 | Port C drive value |
| pc_oe | output | 6 | Port C output enables |

## Verification
The bench builds the block with W = 8 and SYNC_STAGES = 2. At that size every byte value can be written to and read back from both A and B. All sixteen combinations of port C mode and A/B direction can be swept, with the expected enable patterns computed from the mode code. Two stages make the strobe latency short enough to check that buffer-full has not moved after the second edge and has moved after the third. They also make a full strobed transfer in each direction cost only a handful of cycles.

// File: rtl/hsk_pio_pkg.sv
package hsk_pio_pkg;
    typedef enum logic [1:0] {
        PC_IN   = 2'b00,
        PC_HSA  = 2'b01,
        PC_HSAB = 2'b10,
        PC_OUT  = 2'b11
    } pc_mode_t;

    typedef enum logic [2:0] {
        HS_OFF    = 3'd0,
        IN_WAIT   = 3'd1,
        IN_STB    = 3'd2,
        IN_FULL   = 3'd3,
        OUT_EMPTY = 3'd4,
        OUT_FULL  = 3'd5
    } hs_state_t;
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hsk_chan.sv
module hsk_chan
    import hsk_pio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_out,
    input  logic         hs_en,
    input  logic         int_en,
    input  logic         wr,
    input  logic         rd,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    input  logic         stb_n,
    output logic [W-1:0] rdata,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic         bf,
    output logic         intr
);
    hs_state_t    state, nxt;
    logic [W-1:0] out_q, in_q;
    logic         intr_q, stb_prev;
    logic         stb_fall, stb_rise, state_is_out, entry;

    assign stb_fall     = stb_prev & ~stb_n;
    assign stb_rise     = ~stb_prev & stb_n;
    assign state_is_out = (state == OUT_EMPTY) || (state == OUT_FULL);
    assign entry        = (state == HS_OFF) || (state_is_out != dir_out);

    // next-state logic
    always_comb begin
        nxt = state;
        if (!hs_en)      nxt = HS_OFF;
        else if (entry)  nxt = dir_out ? OUT_EMPTY : IN_WAIT;
        else begin
            unique case (state)
                IN_WAIT:   if (stb_fall) nxt = IN_STB;
                IN_STB:    if (stb_rise) nxt = IN_FULL;
                IN_FULL:   if (rd)       nxt = IN_WAIT;
                OUT_EMPTY: if (wr)       nxt = OUT_FULL;
                OUT_FULL:  if (!wr && stb_fall) nxt = OUT_EMPTY;
                default:   nxt = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HS_OFF;
        else        state <= nxt;
    end

    // registered outputs: interrupt, latches, strobe history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intr_q   <= 1'b0;
            out_q    <= '0;
            in_q     <= '0;
            stb_prev <= 1'b1;
        end else begin
            stb_prev <= stb_n;
            if (!hs_en)                                        intr_q <= 1'b0;
            else if (entry)                                    intr_q <= dir_out;
            else if (state == IN_STB && stb_rise && int_en)    intr_q <= 1'b1;
            else if (state == IN_FULL && rd)                   intr_q <= 1'b0;
            else if (state_is_out && wr)                       intr_q <= 1'b0;
            else if (state == OUT_FULL && stb_fall && int_en)  intr_q <= 1'b1;

            if (!dir_out)  out_q <= '0;
            else if (wr)   out_q <= wdata;

            if (hs_en && !entry && state == IN_WAIT && stb_fall) in_q <= pin_in;
        end
    end

    assign bf      = (state == IN_STB) || (state == IN_FULL) || (state == OUT_FULL);
    assign intr    = intr_q;
    assign pin_out = out_q;
    assign pin_oe  = {W{dir_out}};
    assign rdata   = dir_out ? out_q : (hs_en ? in_q : pin_in);

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_en |=> (!bf && !intr)); // R1
    AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_out && wr) |=> (pin_out == '0)); // R3
    AST_ENTRY_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && state == HS_OFF) |=> (!bf && intr == $past(dir_out))); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && !dir_out && state == IN_FULL && rd) |=> (!bf && !intr)); // R7
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && dir_out && state_is_out && wr) |=> (bf && !intr)); // R8
    AST_SAME_VALUE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && wr && wdata == pin_out) |=> $stable(pin_out)); // R10
endmodule

// File: rtl/hsk_pio.sv
module hsk_pio
    import hsk_pio_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [5:0]   cmd_port,
    input  logic [W-1:0] wr_data,
    input  logic         wr_a,
    input  logic         wr_b,
    input  logic         wr_c,
    input  logic         rd_a,
    input  logic         rd_b,
    input  logic         rd_c,
    output logic [W-1:0] rd_a_data,
    output logic [W-1:0] rd_b_data,
    output logic [5:0]   rd_c_data,
    output logic [5:0]   status,
    input  logic [W-1:0] pa_in,
    output logic [W-1:0] pa_out,
    output logic [W-1:0] pa_oe,
    input  logic [W-1:0] pb_in,
    output logic [W-1:0] pb_out,
    output logic [W-1:0] pb_oe,
    input  logic [5:0]   pc_in,
    output logic [5:0]   pc_out,
    output logic [5:0]   pc_oe
);
    localparam int NCH = 2;
    localparam int CW  = 6;

    pc_mode_t mode;
    logic [CW-1:0] pc_q;
    logic [NCH-1:0] ch_hs, ch_dir, ch_en, ch_wr, ch_rd, ch_bf, ch_intr, ch_stb;
    logic [NCH-1:0][W-1:0] ch_pin_in, ch_pin_out, ch_pin_oe, ch_rdata;

    assign mode      = pc_mode_t'(cmd_port[3:2]);
    assign ch_hs[0]  = (mode == PC_HSA) || (mode == PC_HSAB);
    assign ch_hs[1]  = (mode == PC_HSAB);
    assign ch_dir    = cmd_port[1:0];
    assign ch_en     = cmd_port[5:4];
    assign ch_wr     = {wr_b, wr_a};
    assign ch_rd     = {rd_b, rd_a};
    assign ch_pin_in = {pb_in, pa_in};

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        hsk_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(pc_in[gi*3+2]), .q(ch_stb[gi]));
        hsk_chan #(.W(W)) u_chan (
            .clk(clk), .rst_n(rst_n), .dir_out(ch_dir[gi]), .hs_en(ch_hs[gi]),
            .int_en(ch_en[gi]), .wr(ch_wr[gi]), .rd(ch_rd[gi]), .wdata(wr_data),
            .pin_in(ch_pin_in[gi]), .stb_n(ch_stb[gi]), .rdata(ch_rdata[gi]),
            .pin_out(ch_pin_out[gi]), .pin_oe(ch_pin_oe[gi]),
            .bf(ch_bf[gi]), .intr(ch_intr[gi]));
    end

    // port C latch: cleared and write-protected in all-input mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               pc_q <= '0;
        else if (mode == PC_IN)   pc_q <= '0;
        else if (wr_c)            pc_q <= wr_data[CW-1:0];
    end

    always_comb begin
        pc_out = pc_q;
        pc_oe  = (mode == PC_IN) ? '0 : '1;
        for (int i = 0; i < NCH; i++) begin
            if (ch_hs[i]) begin
                pc_out[i*3]   = ch_intr[i];
                pc_out[i*3+1] = ch_bf[i];
                pc_out[i*3+2] = 1'b0;
                pc_oe[i*3+2]  = 1'b0;
            end
        end
    end

    assign rd_c_data = (pc_oe & pc_out) | (~pc_oe & pc_in);
    assign rd_a_data = ch_rdata[0];
    assign rd_b_data = ch_rdata[1];
    assign pa_out    = ch_pin_out[0];
    assign pa_oe     = ch_pin_oe[0];
    assign pb_out    = ch_pin_out[1];
    assign pb_oe     = ch_pin_oe[1];
    assign status    = {ch_en[1], ch_bf[1], ch_intr[1], ch_en[0], ch_bf[0], ch_intr[0]};

    AST_STROBE_PIN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ch_hs[0] |-> !pc_oe[2]); // R5
    AST_C_INPUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PC_IN && wr_c) |=> (pc_q == '0)); // R5
    AST_STATUS_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PC_IN) |=> (status[4:3] == 2'b00 && status[1:0] == 2'b00)); // R9
endmodule

// File: tb/hsk_pio_test.sv
module hsk_pio_test;
    localparam int W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [5:0] cmd_port = '0;
    logic [W-1:0] wr_data = '0;
    logic wr_a = 0, wr_b = 0, wr_c = 0, rd_a = 0, rd_b = 0, rd_c = 0;
    logic [W-1:0] rd_a_data, rd_b_data, pa_out, pa_oe, pb_out, pb_oe;
    logic [W-1:0] pa_in = '0, pb_in = '0;
    logic [5:0] rd_c_data, status, pc_out, pc_oe;
    logic [5:0] pc_in = 6'h3F;
    int total = 0, bad = 0;
    bit done = 0;

    hsk_pio #(.W(W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_port(cmd_port), .wr_data(wr_data),
        .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .rd_a(rd_a), .rd_b(rd_b), .rd_c(rd_c),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .rd_c_data(rd_c_data),
        .status(status), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe));

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_port(input int p, input logic [7:0] d);
        wr_data = d;
        wr_a = (p == 0); wr_b = (p == 1); wr_c = (p == 2);
        step(1);
        wr_a = 0; wr_b = 0; wr_c = 0;
    endtask

    task automatic rd_port(input int p, output logic [7:0] d);
        rd_a = (p == 0); rd_b = (p == 1); rd_c = (p == 2);
        #2;
        d = (p == 0) ? rd_a_data : (p == 1) ? rd_b_data : {2'b00, rd_c_data};
        step(1);
        rd_a = 0; rd_b = 0; rd_c = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [5:0] exp_oe;
        @(negedge clk);
        step(2);
        // R1 reset state
        check("R1 pa_out in reset", pa_out, 8'h00);
        check("R1 status in reset", {2'b00, status}, 8'h00);
        check("R2 pa_oe input in reset", pa_oe, 8'h00);
        rst_n = 1'b1;
        step(1);
        cmd_port = 6'h03;
        step(1);
        check("R1 A latch zero after reset", pa_out, 8'h00);
        check("R1 B latch zero after reset", pb_out, 8'h00);

        // R2 / R5 sweep of all mode and direction combinations
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 4; d++) begin
                cmd_port = 6'(m * 4 + d);
                step(2);
                exp_oe = (m == 0) ? 6'h00 : (m == 3) ? 6'h3F : (m == 1) ? 6'h3B : 6'h1B;
                check("R2 pa_oe", pa_oe, (d & 1) ? 8'hFF : 8'h00);
                check("R2 pb_oe", pb_oe, (d & 2) ? 8'hFF : 8'h00);
                check("R5 pc_oe", {2'b00, pc_oe}, {2'b00, exp_oe});
            end
        end

        // R3 / R4 data sweep, ALT1, both ports output
        cmd_port = 6'h03;
        step(1);
        for (int x = 0; x < 256; x++) begin
            wr_port(0, 8'(x));
            wr_port(1, 8'(255 - x));
            rd_port(0, v); check("R4 A readback", v, 8'(x));
            rd_port(1, v); check("R4 B readback", v, 8'(255 - x));
            check("R3 pa_out", pa_out, 8'(x));
        end
        // R10 rewrite same value
        wr_port(0, 8'hA5);
        check("R10 first write", pa_out, 8'hA5);
        wr_data = 8'hA5; wr_a = 1;
        @(posedge clk); #1 check("R10 same value edge", pa_out, 8'hA5);
        @(negedge clk); wr_a = 0;
        check("R10 same value after", pa_out, 8'hA5);
        // R3 input clears, writes ignored, back to output drives zero
        cmd_port = 6'h00;
        pa_in = 8'h5A;
        step(1);
        wr_port(0, 8'h3C);
        check("R3 latch cleared in input", pa_out, 8'h00);
        rd_port(0, v); check("R4 input reads pins", v, 8'h5A);
        cmd_port = 6'h01;
        step(1);
        check("R3 output after input is zero", pa_out, 8'h00);
        // port C plain modes
        cmd_port = 6'h0C;
        step(1);
        wr_port(2, 8'h2A);
        check("R5 C output drive", {2'b00, pc_out}, 8'h2A);
        rd_port(2, v); check("R4 C read output", v, 8'h2A);
        cmd_port = 6'h00;
        pc_in = 6'h15;
        step(1);
        rd_port(2, v); check("R4 C read input pins", v, 8'h15);
        wr_port(2, 8'h3F);
        cmd_port = 6'h0C;
        step(1);
        check("R5 C latch cleared in all-input", {2'b00, pc_out}, 8'h00);
        pc_in = 6'h3F;

        // R6 entry values, ALT3
        cmd_port = 6'h04;
        step(2);
        check("R6 input entry status", {2'b00, status}, 8'h00);
        cmd_port = 6'h05;
        step(2);
        check("R6 output entry status", {2'b00, status}, 8'h01);
        check("R5 pc0 carries A intr", {7'b0, pc_out[0]}, 8'h01);

        // R7 strobed input with interrupt enabled
        cmd_port = 6'h14;
        pa_in = 8'h81;
        step(2);
        pc_in[2] = 1'b0;
        step(2);
        check("R11 no change after two edges", {2'b00, status}, 8'h04);
        step(1);
        check("R11 R7 bf after third edge", {2'b00, status}, 8'h06);
        check("R5 pc1 carries A bf", {7'b0, pc_out[1]}, 8'h01);
        pa_in = 8'h00;
        pc_in[2] = 1'b1;
        step(3);
        check("R7 R9 intr on strobe release", {2'b00, status}, 8'h07);
        rd_port(0, v); check("R7 captured data", v, 8'h81);
        check("R7 read clears", {2'b00, status}, 8'h04);
        // R7 interrupt disabled
        cmd_port = 6'h04;
        pa_in = 8'h42;
        step(1);
        pc_in[2] = 1'b0; step(4);
        pc_in[2] = 1'b1; step(4);
        check("R7 no intr when disabled", {2'b00, status}, 8'h02);
        rd_port(0, v); check("R7 captured data disabled", v, 8'h42);

        // R8 strobed output on A
        cmd_port = 6'h15;
        step(2);
        check("R6 R8 output entry", {2'b00, status}, 8'h05);
        wr_port(0, 8'h33);
        check("R8 write sets bf clears intr", {2'b00, status}, 8'h06);
        check("R8 data on pins", pa_out, 8'h33);
        pc_in[2] = 1'b0;
        step(3);
        check("R8 strobe empties, raises intr", {2'b00, status}, 8'h05);
        pc_in[2] = 1'b1;
        step(4);

        // R8 / R9 on port B, ALT4
        cmd_port = 6'h2A;
        step(2);
        check("R6 R9 B output entry", {2'b00, status}, 8'h28);
        wr_port(1, 8'hC3);
        check("R8 R9 B write", {2'b00, status}, 8'h30);
        check("R5 pc4 carries B bf", {7'b0, pc_out[4]}, 8'h01);
        pc_in[5] = 1'b0;
        step(3);
        check("R8 R9 B strobe", {2'b00, status}, 8'h28);
        check("R8 B data held", pb_out, 8'hC3);
        pc_in[5] = 1'b1;
        step(2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule